// File: doc/BRIEF.md
# Two-Slot Decoupling Queue with Flush

This block is a two-deep queue that sits between an instruction producer (a fetch stage) and an instruction consumer (an execute stage). The producer offers an item with a valid/ready handshake, the consumer takes items with a second valid/ready handshake, and both can complete in the same cycle. When the consumer detects that the items in flight are on a wrong path, it pulses the flush input and the queue is emptied in one cycle.

The block has a head slot and a tail slot, and each slot has its own valid flag. New items always land in the tail slot. The consumer always reads from the head slot. At the end of every cycle, an item left alone in the tail slot is moved up into the head slot. Both handshake ready/valid outputs come straight from slot valid flags, so no combinational path runs from one side of the queue to the other.

Top module: `pipe_fifo2`

## Requirements
- R1: After reset, `deq_valid` is 0 and `enq_ready` is 1. The data registers are not reset.
- R2: The queue holds at most two items. `enq_ready` is 1 exactly when the queue held fewer than two items at the start of the cycle.
- R3: A push (`enq_valid` and `enq_ready` both 1 at a clock edge) into an empty queue makes `deq_valid` 1 after that edge, with `deq_data` equal to the pushed value.
- R4: A pop (`deq_valid` and `deq_ready` both 1 at a clock edge) removes the oldest item. `deq_data` shows that item for the whole cycle before the edge.
- R5: Items leave in the order they were accepted.
- R6: With one item held, a push and a pop at the same edge leave exactly one item, and that item is the pushed value.
- R7: With two items held, a pop at an edge raises `enq_ready` after that edge, and the second item then appears on `deq_data`.
- R8: A flush at an edge empties the queue. A push or pop in the same cycle has no further effect, and a pushed item is discarded.
- R9: An `enq_valid` while `enq_ready` is 0 is ignored, and a `deq_ready` while `deq_valid` is 0 is ignored. Neither changes the contents.
- R10: Within a cycle, `enq_ready` does not change when `deq_ready` changes, and `deq_valid` does not change when `enq_valid` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Producer offers an item |
| enq_ready | output | 1 | Queue can take an item this cycle |
| enq_data | input | DATA_W | Item from the producer |
| deq_valid | output | 1 | An item is available |
| deq_ready | input | 1 | Consumer takes the item |
| deq_data | output | DATA_W | Oldest item held |
| flush | input | 1 | Discard all held items and any same-cycle push |

## Verification
The bench aims at the following corner cases, and each one names the fault it would expose:

- **Push into an empty queue.** The item must be shifted into the head slot. A design that skips this move shows `deq_valid` low after the push.
- **Push and pop together with one item held.** A design that reads the stale tail slot instead of the incoming value presents the wrong item.
- **Pop from a full queue.** A design that forgets to move the tail item up loses order or drops the item.
- **Flush together with a push.** A design that applies the push after the flush leaks a wrong-path item to the consumer.
- **Handshakes against a full or empty queue, and readiness within a cycle.** Pushes while full and pops while empty must leave the contents unchanged. Toggling one side's input mid-cycle must not move the other side's ready or valid output.

A long stretch of random push, pop and flush traffic is then compared against a reference queue.

// File: rtl/fifo2_pkg.sv
package fifo2_pkg;
   // Source selected for the head slot at the end of a cycle
   typedef enum logic [1:0] {
      HEAD_KEEP = 2'd0,
      HEAD_FROM_TAIL = 2'd1,
      HEAD_FROM_PUSH = 2'd2
   } head_src_e;
endpackage

// File: rtl/fifo2_slot.sv
module fifo2_slot #(
   parameter int DATA_W = 32,
   parameter bit RESET_DATA = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   input  logic              valid_nxt,
   output logic [DATA_W-1:0] q,
   output logic              valid
);
   always_ff @(posedge clk) begin
      if (!rst_n) valid <= 1'b0;
      else        valid <= valid_nxt;
   end

   generate
      if (RESET_DATA) begin : g_data_rst
         always_ff @(posedge clk) begin
            if (!rst_n)    q <= '0;
            else if (load) q <= d;
         end
      end else begin : g_data_norst
         always_ff @(posedge clk) begin
            if (load) q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/fifo2_ctrl.sv
module fifo2_ctrl
   import fifo2_pkg::*;
(
   input  logic      head_v,
   input  logic      tail_v,
   input  logic      enq_valid,
   input  logic      deq_ready,
   input  logic      flush,
   output logic      push_fire,
   output logic      pop_fire,
   output logic      head_v_nxt,
   output logic      tail_v_nxt,
   output head_src_e head_src
);
   logic head_left;
   logic tail_after;

   always_comb begin
      push_fire  = enq_valid && !tail_v;
      pop_fire   = deq_ready && head_v;
      // Intermediate occupancy after pop and push, before the flush
      head_left  = head_v && !pop_fire;
      tail_after = tail_v || push_fire;
      head_src   = HEAD_KEEP;
      head_v_nxt = head_left;
      tail_v_nxt = tail_after;
      if (flush) begin
         head_v_nxt = 1'b0;
         tail_v_nxt = 1'b0;
      end else if (tail_after && !head_left) begin
         // Re-pack: a lone item always sits in the head slot
         head_src   = push_fire ? HEAD_FROM_PUSH : HEAD_FROM_TAIL;
         head_v_nxt = 1'b1;
         tail_v_nxt = 1'b0;
      end
   end
endmodule

// File: rtl/pipe_fifo2.sv
module pipe_fifo2
   import fifo2_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit RESET_DATA = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid,
   output logic              enq_ready,
   input  logic [DATA_W-1:0] enq_data,
   output logic              deq_valid,
   input  logic              deq_ready,
   output logic [DATA_W-1:0] deq_data,
   input  logic              flush
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("pipe_fifo2: DATA_W must be at least 1");
      end
   endgenerate

   logic              head_v, tail_v;
   logic              head_v_nxt, tail_v_nxt;
   logic              push_fire, pop_fire;
   head_src_e         head_src;
   logic [DATA_W-1:0] head_q, tail_q, head_d;

   fifo2_ctrl u_ctrl (
      .head_v     (head_v),
      .tail_v     (tail_v),
      .enq_valid  (enq_valid),
      .deq_ready  (deq_ready),
      .flush      (flush),
      .push_fire  (push_fire),
      .pop_fire   (pop_fire),
      .head_v_nxt (head_v_nxt),
      .tail_v_nxt (tail_v_nxt),
      .head_src   (head_src)
   );

   always_comb begin
      head_d = (head_src == HEAD_FROM_PUSH) ? enq_data : tail_q;
   end

   fifo2_slot #(.DATA_W(DATA_W), .RESET_DATA(RESET_DATA)) u_head (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (head_src != HEAD_KEEP),
      .d         (head_d),
      .valid_nxt (head_v_nxt),
      .q         (head_q),
      .valid     (head_v)
   );

   fifo2_slot #(.DATA_W(DATA_W), .RESET_DATA(RESET_DATA)) u_tail (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (push_fire),
      .d         (enq_data),
      .valid_nxt (tail_v_nxt),
      .q         (tail_q),
      .valid     (tail_v)
   );

   assign enq_ready = !tail_v;
   assign deq_valid = head_v;
   assign deq_data  = head_q;

   // A held tail item implies a held head item
   assert_packed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tail_v |-> head_v);

   assert_empty_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!head_v && enq_valid && enq_ready && !flush)
      |=> (deq_valid && deq_data == $past(enq_data)));

   assert_full_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_v && deq_ready && !flush)
      |=> (enq_ready && deq_valid && deq_data == $past(tail_q)));

   assert_pass_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (head_v && !tail_v && deq_ready && enq_valid && !flush)
      |=> (deq_valid && enq_ready && deq_data == $past(enq_data)));

   assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!deq_valid && enq_ready));

   assert_full_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_v && !deq_ready && !flush)
      |=> (!enq_ready && $stable(deq_data) && $stable(tail_q)));
endmodule

// File: tb/pipe_fifo2_tb_top.sv
module pipe_fifo2_tb_top;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         enq_valid = 1'b0;
   logic         enq_ready;
   logic [W-1:0] enq_data = '0;
   logic         deq_valid;
   logic         deq_ready = 1'b0;
   logic [W-1:0] deq_data;
   logic         flush = 1'b0;

   int n_checks = 0;
   int n_fails  = 0;
   logic [W-1:0] mq[$];

   always #4 clk = ~clk;

   pipe_fifo2 #(.DATA_W(W)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .enq_valid (enq_valid),
      .enq_ready (enq_ready),
      .enq_data  (enq_data),
      .deq_valid (deq_valid),
      .deq_ready (deq_ready),
      .deq_data  (deq_data),
      .flush     (flush)
   );

   task automatic check(input string tag, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // One cycle: drive at the falling edge, compare with the model, then clock
   task automatic step(input string tag, input logic pv, input logic [W-1:0] pd,
                       input logic pr, input logic fl);
      bit push_ok, pop_ok;
      @(negedge clk);
      enq_valid = pv; enq_data = pd; deq_ready = pr; flush = fl;
      #1;
      check(tag, "enq_ready", W'(enq_ready), W'(mq.size() < 2));
      check(tag, "deq_valid", W'(deq_valid), W'(mq.size() > 0));
      if (mq.size() > 0) check(tag, "deq_data", deq_data, mq[0]);
      push_ok = pv && (mq.size() < 2);
      pop_ok  = pr && (mq.size() > 0);
      @(posedge clk);
      if (pop_ok)  void'(mq.pop_front());
      if (push_ok) mq.push_back(pd);
      if (fl)      mq.delete();
   endtask

   task automatic idle(input string tag);
      step(tag, 1'b0, '0, 1'b0, 1'b0);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      mq.delete();
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1", "enq_ready after reset", W'(enq_ready), W'(1));
      check("R1", "deq_valid after reset", W'(deq_valid), W'(0));
   endtask

   task automatic t_empty_push;
      step("R3", 1'b1, 16'h00A1, 1'b0, 1'b0);
      idle("R3");
      step("R4", 1'b0, '0, 1'b1, 1'b0);
      idle("R4");
   endtask

   task automatic t_fill_and_order;
      step("R2", 1'b1, 16'h0B01, 1'b0, 1'b0);
      step("R2", 1'b1, 16'h0B02, 1'b0, 1'b0);
      step("R9", 1'b1, 16'hDEAD, 1'b0, 1'b0); // refused: full
      idle("R2");
      step("R7", 1'b0, '0, 1'b1, 1'b0);
      idle("R7");
      step("R5", 1'b0, '0, 1'b1, 1'b0);
      idle("R5");
   endtask

   task automatic t_push_pop_one;
      step("R6", 1'b1, 16'h0C01, 1'b0, 1'b0);
      step("R6", 1'b1, 16'h0C02, 1'b1, 1'b0);
      step("R6", 1'b1, 16'h0C03, 1'b1, 1'b0);
      idle("R6");
      step("R6", 1'b0, '0, 1'b1, 1'b0);
      idle("R6");
   endtask

   task automatic t_empty_pop;
      step("R9", 1'b0, '0, 1'b1, 1'b0);
      step("R9", 1'b0, '0, 1'b1, 1'b0);
      idle("R9");
   endtask

   task automatic t_flush;
      step("R8", 1'b1, 16'h0D01, 1'b0, 1'b0);
      step("R8", 1'b1, 16'h0D02, 1'b0, 1'b0);
      step("R8", 1'b0, '0, 1'b0, 1'b1);
      idle("R8");
      step("R8", 1'b1, 16'h0D03, 1'b0, 1'b1); // push discarded
      idle("R8");
      step("R8", 1'b1, 16'h0D04, 1'b1, 1'b1); // push and pop with flush
      idle("R8");
   endtask

   task automatic t_no_comb_path;
      logic a, b;
      step("R10", 1'b1, 16'h0E01, 1'b0, 1'b0);
      @(negedge clk);
      enq_valid = 1'b0; deq_ready = 1'b0; #1; a = enq_ready; b = deq_valid;
      deq_ready = 1'b1; #1;
      check("R10", "enq_ready vs deq_ready", W'(enq_ready), W'(a));
      enq_valid = 1'b1; #1;
      check("R10", "deq_valid vs enq_valid", W'(deq_valid), W'(b));
      deq_ready = 1'b0; enq_valid = 1'b0;
      @(posedge clk);
      step("R10", 1'b0, '0, 1'b1, 1'b1);
      idle("R10");
   endtask

   task automatic t_random;
      for (int i = 0; i < 3000; i++) begin
         step("R5", 1'($urandom_range(0, 1)), W'($urandom),
              1'($urandom_range(0, 1)), ($urandom_range(0, 19) == 0));
      end
   endtask

   initial begin
      #2_000_000;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      t_reset();
      t_empty_push();
      t_fill_and_order();
      t_push_pop_one();
      t_empty_pop();
      t_flush();
      t_no_comb_path();
      t_random();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule